// File: doc/BRIEF.md
# DMA Control Register Window with Host and Backend Access

This block holds a 16-byte bank of DMA control registers and decides which accesses reach it. Two sides can reach the bank. The host bus reaches it through configuration cycles and, depending on a location parameter, through one dedicated memory or I/O base address region. A local backend port reaches it by word index. The block matches host addresses against the window at byte offsets 0x50 to 0x5F. It applies a read and write permission to each path. It resolves same-cycle write collisions between the two sides and swallows stray hits inside the dedicated region so that they never reach user logic.

The bank has four 32-bit words: a 16-bit control field (word 0), a source address (word 1), a destination address (word 2) and a transfer count of `CNT_W` bits (word 3). The transfer length that the block presents treats a count of zero as the largest transfer, which is 2^`CNT_W` bytes. An optional direct-data mode sends host data beats to an internal register instead of the backend data path. All results are registered and appear one clock after the access is presented.

Top module: `dma_regwin`

## Requirements
- R1: After a synchronous reset, every register word reads zero. `dd_valid`, `h_ack` and `b_ack` are 0, and `xfer_len` equals 2^`CNT_W`.
- R2: A host configuration read (`h_space`=0) whose dword address `h_dwaddr[5:2]` equals 5 is acknowledged in every location setting. It returns word `h_dwaddr[1:0]` on `h_rdata` one cycle later.
- R3: With `LOC_MODE`=0, host configuration writes to the window are acknowledged but change no register. Backend writes still update the bank.
- R4: Host writes apply per byte lane: byte i of the addressed word changes only when `h_be[i]` is 1. With `LOC_MODE`≥1, host configuration writes are permitted.
- R5: With `LOC_MODE`=2 (memory, `h_space`=1) or 3 (I/O, `h_space`=2), accesses whose `h_bar` equals `BAR_SEL` and whose address is inside the window read and write the bank. Other region numbers and other spaces do not hit the bank.
- R6: Any access to the dedicated region is acknowledged and gives `h_to_user`=0. Outside the window, such reads return zero and such writes change nothing. Other memory or I/O accesses give `h_to_user`=1 and `h_ack`=0.
- R7: With `BACKEND_EN`=1, the backend reads and writes word `b_word` with byte enables. `b_ack` and `b_rdata` follow one cycle later.
- R8: When a permitted host write and a backend write target the same word in the same cycle, only the host write lands. `b_retry` is 1 and `b_ack` is 0 for exactly the next cycle. Writes to different words in the same cycle both land.
- R9: Unimplemented bits read zero: bits 31:16 of word 0, and bits 31:`CNT_W` of word 3.
- R10: `xfer_len` equals the count register, or 2^`CNT_W` when the count register is zero. It follows a count write one cycle later.
- R11: With `DIRECT_EN`=1, host data beats write and read an internal register, `bd_we` stays 0, and `dd_valid` rises after the first write and stays high. With `DIRECT_EN`=0, writes are forwarded on `bd_we`/`bd_wdata` and reads return `bd_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_valid | input | 1 | Host access present this cycle |
| h_space | input | 2 | Host space: 0 config, 1 memory, 2 I/O |
| h_bar | input | 3 | Host base region number (memory/I/O) |
| h_dwaddr | input | 6 | Host dword address (byte offset bits 7:2) |
| h_write | input | 1 | Host access is a write |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_ack | output | 1 | Access claimed by this block |
| h_to_user | output | 1 | Access may be forwarded to user logic |
| h_rdata | output | 32 | Host read data |
| b_valid | input | 1 | Backend access present |
| b_write | input | 1 | Backend access is a write |
| b_word | input | 2 | Backend word index |
| b_be | input | 4 | Backend byte enables |
| b_wdata | input | 32 | Backend write data |
| b_ack | output | 1 | Backend access accepted |
| b_retry | output | 1 | Backend write lost a collision |
| b_rdata | output | 32 | Backend read data |
| hd_valid | input | 1 | Host data beat present |
| hd_write | input | 1 | Host data beat is a write |
| hd_wdata | input | 32 | Host data beat write data |
| hd_rdata | output | 32 | Host data beat read data |
| dd_valid | output | 1 | Direct data register has been written |
| bd_rdata | input | 32 | Backend data path read data |
| bd_we | output | 1 | Backend data path write strobe |
| bd_wdata | output | 32 | Backend data path write data |
| dma_ctrl | output | 16 | Control field |
| dma_src | output | 32 | Source address |
| dma_dst | output | 32 | Destination address |
| dma_cnt | output | CNT_W | Transfer count |
| xfer_len | output | CNT_W+1 | Effective transfer length in bytes |

## Verification
Every acknowledge, read datum, forward flag, retry flag and data-path strobe is due exactly one clock after the cycle that presents the access. A register write is visible to a read presented in the next cycle, and `xfer_len` moves one clock after a count write. The driver presents stimulus on falling edges and queues each expectation tagged with the cycle index in which it becomes due. The monitor compares the outputs only on the falling edge of that cycle, so each sample is taken half a period after the register has updated. Two instances share the stimulus: one with the dedicated memory region and direct mode, and one that is read-only from the host. Each collision, lane and window-boundary case therefore has a known expected value on both.

// File: rtl/dma_regwin_pkg.sv
package dma_regwin_pkg;
  localparam logic [1:0] SP_CFG = 2'd0;
  localparam logic [1:0] SP_MEM = 2'd1;
  localparam logic [1:0] SP_IO  = 2'd2;
  localparam logic [3:0] WIN_HI = 4'h5;   // byte offsets 0x50..0x5F
  localparam int NWORDS = 4;

  function automatic logic [31:0] word_mask(input int w, input int cw);
    logic [31:0] m;
    m = '1;
    if (w == 0) m = 32'h0000_FFFF;
    else if (w == NWORDS - 1 && cw < 32) m = (32'd1 << cw) - 32'd1;
    return m;
  endfunction
endpackage

// File: rtl/dma_regwin_hdec.sv
module dma_regwin_hdec
  import dma_regwin_pkg::*;
#(
  parameter int LOC_MODE = 2,
  parameter int BAR_SEL  = 0
) (
  input  logic       valid,
  input  logic [1:0] space,
  input  logic [2:0] bar,
  input  logic [5:0] dwaddr,
  input  logic       write,
  output logic       reg_rd,
  output logic       reg_wr,
  output logic       claim,
  output logic       to_user,
  output logic [1:0] word
);
  logic in_win, ded_bar, cfg_hit, bar_hit;

  always_comb begin
    in_win  = (dwaddr[5:2] == WIN_HI);
    ded_bar = (bar == 3'(BAR_SEL)) &&
              (((LOC_MODE == 2) && (space == SP_MEM)) ||
               ((LOC_MODE == 3) && (space == SP_IO)));
    cfg_hit = valid && (space == SP_CFG) && in_win;
    bar_hit = valid && ded_bar && in_win;
    reg_rd  = (cfg_hit || bar_hit) && !write;
    reg_wr  = write && ((cfg_hit && (LOC_MODE != 0)) || bar_hit);
    claim   = cfg_hit || (valid && ded_bar);
    to_user = valid && (space != SP_CFG) && !ded_bar;
    word    = dwaddr[1:0];
  end
endmodule

// File: rtl/dma_regwin_bank.sv
module dma_regwin_bank
  import dma_regwin_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             h_we,
  input  logic [1:0]       h_word,
  input  logic [3:0]       h_be,
  input  logic [31:0]      h_wdata,
  input  logic             b_we,
  input  logic [1:0]       b_word,
  input  logic [3:0]       b_be,
  input  logic [31:0]      b_wdata,
  input  logic [1:0]       h_rword,
  input  logic [1:0]       b_rword,
  output logic [31:0]      h_rd,
  output logic [31:0]      b_rd,
  output logic [15:0]      ctrl,
  output logic [31:0]      src,
  output logic [31:0]      dst,
  output logic [CNT_W-1:0] cnt
);
  logic [NWORDS-1:0][31:0] regs;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else begin
      for (int w = 0; w < NWORDS; w++) begin
        for (int i = 0; i < 4; i++) begin
          if (h_we && h_word == 2'(w) && h_be[i])
            regs[w][i*8 +: 8] <= h_wdata[i*8 +: 8] & word_mask(w, CNT_W)[i*8 +: 8];
          else if (b_we && b_word == 2'(w) && b_be[i])
            regs[w][i*8 +: 8] <= b_wdata[i*8 +: 8] & word_mask(w, CNT_W)[i*8 +: 8];
        end
      end
    end
  end

  always_comb begin
    h_rd = regs[h_rword];
    b_rd = regs[b_rword];
    ctrl = regs[0][15:0];
    src  = regs[1];
    dst  = regs[2];
    cnt  = regs[NWORDS-1][CNT_W-1:0];
  end

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    ($past(!h_we) && $past(!b_we)) |-> $stable(regs)) else $error("bank moved without write"); // R3

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (regs[0][31:16] == 16'h0)) else $error("unimplemented control bits set"); // R9
endmodule

// File: rtl/dma_regwin_ddata.sv
module dma_regwin_ddata #(
  parameter int DIRECT_EN = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        hd_valid,
  input  logic        hd_write,
  input  logic [31:0] hd_wdata,
  input  logic [31:0] bd_rdata,
  output logic [31:0] hd_rdata,
  output logic        dd_valid,
  output logic        bd_we,
  output logic [31:0] bd_wdata
);
  generate
    if (DIRECT_EN != 0) begin : g_direct
      logic [31:0] dd_reg;
      always_ff @(posedge clk) begin
        if (rst) begin
          dd_reg   <= '0;
          dd_valid <= 1'b0;
          hd_rdata <= '0;
        end else if (hd_valid) begin
          if (hd_write) begin
            dd_reg   <= hd_wdata;
            dd_valid <= 1'b1;
          end else begin
            hd_rdata <= dd_reg;
          end
        end
      end
      assign bd_we    = 1'b0;
      assign bd_wdata = '0;
    end else begin : g_pass
      always_ff @(posedge clk) begin
        if (rst) begin
          bd_we    <= 1'b0;
          bd_wdata <= '0;
          hd_rdata <= '0;
        end else begin
          bd_we <= hd_valid && hd_write;
          if (hd_valid && hd_write) bd_wdata <= hd_wdata;
          if (hd_valid && !hd_write) hd_rdata <= bd_rdata;
        end
      end
      assign dd_valid = 1'b0;
    end
  endgenerate

  AST_DD_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(dd_valid) |-> dd_valid) else $error("direct data valid dropped"); // R11
endmodule

// File: rtl/dma_regwin.sv
module dma_regwin
  import dma_regwin_pkg::*;
#(
  parameter int LOC_MODE   = 2,
  parameter int BAR_SEL    = 0,
  parameter int CNT_W      = 16,
  parameter int BACKEND_EN = 1,
  parameter int DIRECT_EN  = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             h_valid,
  input  logic [1:0]       h_space,
  input  logic [2:0]       h_bar,
  input  logic [5:0]       h_dwaddr,
  input  logic             h_write,
  input  logic [3:0]       h_be,
  input  logic [31:0]      h_wdata,
  output logic             h_ack,
  output logic             h_to_user,
  output logic [31:0]      h_rdata,
  input  logic             b_valid,
  input  logic             b_write,
  input  logic [1:0]       b_word,
  input  logic [3:0]       b_be,
  input  logic [31:0]      b_wdata,
  output logic             b_ack,
  output logic             b_retry,
  output logic [31:0]      b_rdata,
  input  logic             hd_valid,
  input  logic             hd_write,
  input  logic [31:0]      hd_wdata,
  output logic [31:0]      hd_rdata,
  output logic             dd_valid,
  input  logic [31:0]      bd_rdata,
  output logic             bd_we,
  output logic [31:0]      bd_wdata,
  output logic [15:0]      dma_ctrl,
  output logic [31:0]      dma_src,
  output logic [31:0]      dma_dst,
  output logic [CNT_W-1:0] dma_cnt,
  output logic [CNT_W:0]   xfer_len
);
  logic       reg_rd, reg_wr, claim, to_user;
  logic [1:0] h_word;
  logic       b_wr_req, b_rd_req, conflict, b_we;
  logic [31:0] h_rd, b_rd;

  dma_regwin_hdec #(.LOC_MODE(LOC_MODE), .BAR_SEL(BAR_SEL)) u_hdec (
    .valid(h_valid), .space(h_space), .bar(h_bar), .dwaddr(h_dwaddr),
    .write(h_write), .reg_rd(reg_rd), .reg_wr(reg_wr), .claim(claim),
    .to_user(to_user), .word(h_word)
  );

  generate
    if (BACKEND_EN != 0) begin : g_be
      assign b_wr_req = b_valid && b_write;
      assign b_rd_req = b_valid && !b_write;
    end else begin : g_nobe
      assign b_wr_req = 1'b0;
      assign b_rd_req = 1'b0;
    end
  endgenerate

  assign conflict = reg_wr && b_wr_req && (h_word == b_word);
  assign b_we     = b_wr_req && !conflict;

  dma_regwin_bank #(.CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst(rst),
    .h_we(reg_wr), .h_word(h_word), .h_be(h_be), .h_wdata(h_wdata),
    .b_we(b_we), .b_word(b_word), .b_be(b_be), .b_wdata(b_wdata),
    .h_rword(h_word), .b_rword(b_word), .h_rd(h_rd), .b_rd(b_rd),
    .ctrl(dma_ctrl), .src(dma_src), .dst(dma_dst), .cnt(dma_cnt)
  );

  dma_regwin_ddata #(.DIRECT_EN(DIRECT_EN)) u_ddata (
    .clk(clk), .rst(rst), .hd_valid(hd_valid), .hd_write(hd_write),
    .hd_wdata(hd_wdata), .bd_rdata(bd_rdata), .hd_rdata(hd_rdata),
    .dd_valid(dd_valid), .bd_we(bd_we), .bd_wdata(bd_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      h_ack     <= 1'b0;
      h_to_user <= 1'b0;
      h_rdata   <= '0;
      b_ack     <= 1'b0;
      b_retry   <= 1'b0;
      b_rdata   <= '0;
    end else begin
      h_ack     <= claim;
      h_to_user <= to_user;
      if (h_valid) h_rdata <= reg_rd ? h_rd : 32'h0;
      b_ack     <= (b_wr_req || b_rd_req) && !conflict;
      b_retry   <= conflict;
      if (b_rd_req) b_rdata <= b_rd;
    end
  end

  assign xfer_len = (dma_cnt == '0) ? ((CNT_W+1)'(1) << CNT_W) : {1'b0, dma_cnt};

  AST_CFG_READ_ACK: assert property (@(posedge clk) disable iff (rst)
    $past(h_valid && h_space == SP_CFG && h_dwaddr[5:2] == WIN_HI && !h_write) |-> h_ack)
    else $error("config window read not claimed"); // R2

  AST_NO_USER_FWD: assert property (@(posedge clk) disable iff (rst)
    !(h_ack && h_to_user)) else $error("claimed access also forwarded"); // R6

  AST_RETRY_CAUSE: assert property (@(posedge clk) disable iff (rst)
    b_retry |-> ($past(b_valid && b_write && h_valid && h_write) && !b_ack))
    else $error("retry without colliding writes"); // R8

  AST_XFER_NONZERO: assert property (@(posedge clk) disable iff (rst)
    xfer_len != '0) else $error("zero transfer length"); // R10
endmodule

// File: tb/dma_regwin_tb.sv
module dma_regwin_tb;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;   // 200 MHz

  logic h_valid = 0, h_write = 0, b_valid = 0, b_write = 0, hd_valid = 0, hd_write = 0;
  logic [1:0] h_space = 0, b_word = 0;
  logic [2:0] h_bar = 0;
  logic [5:0] h_dwaddr = 0;
  logic [3:0] h_be = 0, b_be = 0;
  logic [31:0] h_wdata = 0, b_wdata = 0, hd_wdata = 0, bd_rdata = 0;

  logic a_hack, a_huser, a_back, a_bretry, a_ddv, a_bdwe;
  logic [31:0] a_hrd, a_brd, a_hdrd, a_bdwd, a_src, a_dst;
  logic [15:0] a_ctrl;
  logic [CW-1:0] a_cnt;
  logic [CW:0] a_xlen;
  logic z_hack, z_huser, z_back, z_bretry, z_ddv, z_bdwe;
  logic [31:0] z_hrd, z_brd, z_hdrd, z_bdwd, z_src, z_dst;
  logic [15:0] z_ctrl;
  logic [CW-1:0] z_cnt;
  logic [CW:0] z_xlen;

  dma_regwin #(.LOC_MODE(2), .BAR_SEL(3), .CNT_W(CW), .BACKEND_EN(1), .DIRECT_EN(1)) u_dut (
    .clk(clk), .rst(rst), .h_valid(h_valid), .h_space(h_space), .h_bar(h_bar),
    .h_dwaddr(h_dwaddr), .h_write(h_write), .h_be(h_be), .h_wdata(h_wdata),
    .h_ack(a_hack), .h_to_user(a_huser), .h_rdata(a_hrd),
    .b_valid(b_valid), .b_write(b_write), .b_word(b_word), .b_be(b_be), .b_wdata(b_wdata),
    .b_ack(a_back), .b_retry(a_bretry), .b_rdata(a_brd),
    .hd_valid(hd_valid), .hd_write(hd_write), .hd_wdata(hd_wdata), .hd_rdata(a_hdrd),
    .dd_valid(a_ddv), .bd_rdata(bd_rdata), .bd_we(a_bdwe), .bd_wdata(a_bdwd),
    .dma_ctrl(a_ctrl), .dma_src(a_src), .dma_dst(a_dst), .dma_cnt(a_cnt), .xfer_len(a_xlen)
  );

  dma_regwin #(.LOC_MODE(0), .BAR_SEL(3), .CNT_W(CW), .BACKEND_EN(1), .DIRECT_EN(0)) u_dut0 (
    .clk(clk), .rst(rst), .h_valid(h_valid), .h_space(h_space), .h_bar(h_bar),
    .h_dwaddr(h_dwaddr), .h_write(h_write), .h_be(h_be), .h_wdata(h_wdata),
    .h_ack(z_hack), .h_to_user(z_huser), .h_rdata(z_hrd),
    .b_valid(b_valid), .b_write(b_write), .b_word(b_word), .b_be(b_be), .b_wdata(b_wdata),
    .b_ack(z_back), .b_retry(z_bretry), .b_rdata(z_brd),
    .hd_valid(hd_valid), .hd_write(hd_write), .hd_wdata(hd_wdata), .hd_rdata(z_hdrd),
    .dd_valid(z_ddv), .bd_rdata(bd_rdata), .bd_we(z_bdwe), .bd_wdata(z_bdwd),
    .dma_ctrl(z_ctrl), .dma_src(z_src), .dma_dst(z_dst), .dma_cnt(z_cnt), .xfer_len(z_xlen)
  );

  typedef struct { int due; int sel; logic [31:0] exp; string req; } item_t;
  item_t sb[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] probe(input int sel);
    case (sel)
      0: return {31'b0, a_hack};   1: return a_hrd;      2: return {31'b0, a_huser};
      3: return {31'b0, a_back};   4: return a_brd;      5: return {31'b0, a_bretry};
      6: return 32'(a_xlen);       7: return a_hdrd;     8: return {31'b0, a_ddv};
      9: return {31'b0, a_bdwe};   10: return z_hrd;     11: return {31'b0, z_hack};
      12: return {31'b0, z_back};  13: return {31'b0, z_bdwe}; 14: return z_hdrd;
      default: return 32'hDEAD_DEAD;
    endcase
  endfunction

  // monitor: compares each queued expectation in the cycle it is due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = probe(it.sel);
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_at(input int sel, input logic [31:0] v, input string req);
    item_t it;
    it.due = cyc + 1; it.sel = sel; it.exp = v; it.req = req;
    sb.push_back(it);
  endtask

  task automatic set_h(input logic [1:0] sp, input logic [2:0] bar, input logic [7:0] byte_off,
                       input logic wr, input logic [3:0] be, input logic [31:0] d);
    h_valid = 1; h_space = sp; h_bar = bar; h_dwaddr = byte_off[7:2];
    h_write = wr; h_be = be; h_wdata = d;
  endtask

  task automatic set_b(input logic wr, input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
    b_valid = 1; b_write = wr; b_word = w; b_be = be; b_wdata = d;
  endtask

  task automatic step();
    @(negedge clk);
    h_valid = 0; b_valid = 0; hd_valid = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // reset state
    expect_at(0, 0, "R1"); expect_at(8, 0, "R1"); expect_at(6, 32'd4096, "R1");
    expect_at(11, 0, "R1"); expect_at(3, 0, "R1");
    step();
    set_h(2'd0, 3'd0, 8'h5C, 0, 4'hF, 0); expect_at(1, 0, "R1"); step();

    // read-only host in location setting 0
    set_h(2'd0, 3'd0, 8'h54, 1, 4'hF, 32'h1234_5678); expect_at(11, 1, "R3"); step();
    set_h(2'd0, 3'd0, 8'h54, 0, 4'hF, 0);
    expect_at(10, 0, "R3"); expect_at(1, 32'h1234_5678, "R2"); step();
    set_b(1, 2'd1, 4'hF, 32'h0000_0009); expect_at(3, 1, "R7"); expect_at(12, 1, "R3"); step();
    set_h(2'd0, 3'd0, 8'h54, 0, 4'hF, 0);
    expect_at(10, 32'h9, "R3"); expect_at(1, 32'h9, "R7"); step();

    // direct-data versus pass-through
    hd_valid = 1; hd_write = 1; hd_wdata = 32'h77;
    expect_at(13, 1, "R11"); expect_at(9, 0, "R11"); expect_at(8, 1, "R11"); step();
    hd_valid = 1; hd_write = 0; bd_rdata = 32'hBEEF;
    expect_at(7, 32'h77, "R11"); expect_at(14, 32'hBEEF, "R11"); step();

    // configuration write allowed when location setting is above 0
    set_h(2'd0, 3'd0, 8'h54, 1, 4'hF, 32'h1122_3344); step();
    set_h(2'd0, 3'd0, 8'h54, 0, 4'hF, 0); expect_at(1, 32'h1122_3344, "R4"); step();

    // dedicated memory region, byte lanes
    set_h(2'd1, 3'd3, 8'h58, 1, 4'b0101, 32'hAABB_CCDD); step();
    set_h(2'd1, 3'd3, 8'h58, 0, 4'hF, 0);
    expect_at(1, 32'h00BB_00DD, "R4"); expect_at(0, 1, "R5"); expect_at(2, 0, "R5"); step();
    set_h(2'd1, 3'd2, 8'h58, 0, 4'hF, 0); expect_at(0, 0, "R5"); expect_at(2, 1, "R6"); step();
    set_h(2'd2, 3'd3, 8'h58, 0, 4'hF, 0); expect_at(0, 0, "R5"); expect_at(2, 1, "R6"); step();

    // stray hits in the dedicated region
    set_h(2'd1, 3'd3, 8'h24, 1, 4'hF, 32'hFFFF_FFFF); expect_at(0, 1, "R6"); expect_at(2, 0, "R6"); step();
    set_h(2'd1, 3'd3, 8'h24, 0, 4'hF, 0); expect_at(1, 0, "R6"); expect_at(0, 1, "R6"); step();
    set_h(2'd0, 3'd0, 8'h54, 0, 4'hF, 0); expect_at(1, 32'h1122_3344, "R6"); step();

    // unimplemented bits and transfer length
    set_h(2'd1, 3'd3, 8'h50, 1, 4'hF, 32'hFFFF_FFFF); step();
    set_h(2'd1, 3'd3, 8'h50, 0, 4'hF, 0); expect_at(1, 32'h0000_FFFF, "R9"); step();
    set_h(2'd1, 3'd3, 8'h5C, 1, 4'hF, 32'hFFFF_FFFF); expect_at(6, 32'hFFF, "R10"); step();
    set_h(2'd1, 3'd3, 8'h5C, 0, 4'hF, 0); expect_at(1, 32'h0000_0FFF, "R9"); step();
    set_h(2'd1, 3'd3, 8'h5C, 1, 4'hF, 32'h0); expect_at(6, 32'd4096, "R10"); step();

    // backend read
    set_b(0, 2'd2, 4'hF, 0); expect_at(4, 32'h00BB_00DD, "R7"); expect_at(3, 1, "R7"); step();

    // same-word collision: host wins, one-cycle retry
    set_h(2'd1, 3'd3, 8'h54, 1, 4'hF, 32'h0101_0101);
    set_b(1, 2'd1, 4'hF, 32'h0202_0202);
    expect_at(5, 1, "R8"); expect_at(3, 0, "R8"); step();
    expect_at(5, 0, "R8"); step();
    set_h(2'd1, 3'd3, 8'h54, 0, 4'hF, 0); expect_at(1, 32'h0101_0101, "R8"); step();

    // different words in the same cycle both land
    set_h(2'd1, 3'd3, 8'h50, 1, 4'b0001, 32'h0000_00AB);
    set_b(1, 2'd2, 4'hF, 32'h0000_0CDE);
    expect_at(5, 0, "R8"); expect_at(3, 1, "R8"); step();
    set_b(0, 2'd2, 4'hF, 0); expect_at(4, 32'h0000_0CDE, "R8"); step();
    set_h(2'd1, 3'd3, 8'h50, 0, 4'hF, 0); expect_at(1, 32'h0000_FFAB, "R4"); step();

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule